// File: doc/BRIEF.md
# Grouped Interrupt Request Register File

This block keeps the per-group interrupt state of an interrupt controller: thirty-one groups of four request lines each. The two lowest groups are non-maskable; the rest are maskable and carry a four-bit enable mask and a three-bit priority level. Incoming lines are sampled every clock. A line in edge mode latches its request bit on any change of its value. A line in level mode latches its request bit while it is high. The request bit stays set after the line returns low.

Software reaches the state through a byte-wide register bus with a combinational read. Each group owns a four-byte slot. Maskable groups expose a status byte and a configuration byte. Non-maskable groups expose a clear-on-write status byte and an injection byte that software uses to raise a request itself. The complete request, enable and level vectors are exported flat so that a separate priority resolver can pick the winning group. A one-cycle non-maskable pulse is produced when an input event in a non-maskable group leaves that group with an enabled request.

Top module: `irq_group_regfile`

## Requirements
- R1: After reset every request bit and level field is zero, the enable mask of groups 0 and 1 is 4'hF, every other enable mask is zero, and `nmi_pulse` is low.
- R2: Byte address A selects group A/4 and byte A%4. Addresses of 124 and above, and bytes with no function listed below, read as 8'h00 and ignore writes.
- R3: For a maskable group, byte 1 reads as {1'b0, level[2:0], enable[3:0]}. A write to it loads level from bits 6:4 and enable from bits 3:0, and bit 7 is dropped.
- R4: For a maskable group, byte 0 reads as {request[3:0], request & enable}.
- R5: A write to byte 0 of a maskable group treats bits 7:4 as U and bits 3:0 as L. For each bit i, L=1 loads request[i] with U[i], and L=0 keeps request[i].
- R6: For a non-maskable group, byte 0 reads as {4'h0, request[3:0]}. A write to byte 0 clears every request bit written as 1.
- R7: For a non-maskable group, a write to byte 3 sets every request bit written as 1. The enable mask cannot be changed, and byte 1 reads as zero.
- R8: In edge mode (`line_edge_mode` bit = 1), any change of a line's value, rising or falling, sets its request bit at the next clock edge.
- R9: In level mode, a high line sets its request bit at every clock edge. A low line never clears the request bit.
- R10: `nmi_pulse` is high for the cycle that follows a clock edge at which a line of groups 0 or 1 changed value and left that group's request AND enable nonzero. It is low at all other times.
- R11: When a request bit is set by an input and cleared by a bus write in the same cycle, the bit ends up set.
- R12: Line g*4+i drives `req_vec`/`en_vec` bit g*4+i, and group g's level appears in `lvl_vec[g*3 +: 3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 124 | Request lines, line i of group g at bit g*4+i |
| line_edge_mode | input | 124 | Per line: 1 = edge mode, 0 = level mode |
| bus_addr | input | 7 | Register byte address |
| bus_we | input | 1 | Write strobe for `bus_wdata` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| nmi_pulse | output | 1 | One-cycle non-maskable request |
| req_vec | output | 124 | Latched request bits |
| en_vec | output | 124 | Enable masks |
| lvl_vec | output | 93 | Three-bit level per group |

## Verification
An input event and a software write can target the same request bit in the same clock. This matters most when a status-byte write clears a bit while the line that sets it changes, or while a level-mode line is still high. The bench provokes both cases. It raises an edge-mode line in the same cycle as a clearing write, and it clears a level-mode bit while the line is held high. In both cases it reads the status byte back and expects the bit still set. The non-maskable pulse is judged cycle by cycle. Injected requests produce no pulse, and a line event does.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

    localparam int GRP_LINES  = 4;
    localparam int GRP_LVL_W  = 3;
    localparam int GRP_COUNT  = 31;
    localparam int GRP_NMI    = 2;

    typedef enum logic [1:0] {
        BYTE_STAT = 2'd0,
        BYTE_CFG  = 2'd1,
        BYTE_RSV  = 2'd2,
        BYTE_INJ  = 2'd3
    } grp_byte_e;

    typedef struct packed {
        logic [GRP_LINES-1:0] req;
        logic [GRP_LINES-1:0] en;
        logic [GRP_LVL_W-1:0] lvl;
    } grp_state_t;

    // Paired nibble update: where the low nibble is 1 the bit takes the high nibble.
    function automatic logic [GRP_LINES-1:0] pair_update(
        input logic [GRP_LINES-1:0] old_req,
        input logic [7:0]           wdata
    );
        logic [GRP_LINES-1:0] up;
        logic [GRP_LINES-1:0] lo;
        up = wdata[7:4];
        lo = wdata[3:0];
        return (lo & up) | (~lo & old_req);
    endfunction

endpackage

// File: rtl/irq_line_capture.sv
module irq_line_capture
    import irq_grp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GRP_LINES-1:0] line_in,
    input  logic [GRP_LINES-1:0] edge_mode,
    output logic [GRP_LINES-1:0] line_evt,
    output logic [GRP_LINES-1:0] set_bits
);

    logic [GRP_LINES-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_in;
    end

    assign line_evt = line_in ^ line_q;
    assign set_bits = (edge_mode & line_evt) | (~edge_mode & line_in);

endmodule

// File: rtl/irq_group_slot.sv
module irq_group_slot
    import irq_grp_pkg::*;
#(
    parameter bit IS_NMI = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hit,
    input  logic [1:0]           byte_sel,
    input  logic [7:0]           wdata,
    input  logic [GRP_LINES-1:0] set_bits,
    input  logic [GRP_LINES-1:0] line_evt,
    output logic [7:0]           rdata,
    output grp_state_t           state,
    output logic                 nmi_fire
);

    localparam logic [GRP_LINES-1:0] EN_RESET = IS_NMI ? '1 : '0;

    grp_state_t st_q;
    grp_state_t st_d;
    grp_byte_e  bsel;

    assign bsel = grp_byte_e'(byte_sel);

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            if (IS_NMI) begin
                if (bsel == BYTE_STAT)     st_d.req = st_q.req & ~wdata[3:0];
                else if (bsel == BYTE_INJ) st_d.req = st_q.req | wdata[3:0];
            end else begin
                if (bsel == BYTE_STAT) begin
                    st_d.req = pair_update(st_q.req, wdata);
                end else if (bsel == BYTE_CFG) begin
                    st_d.lvl = wdata[6:4];
                    st_d.en  = wdata[3:0];
                end
            end
        end
        // Input events take precedence over a same-cycle clear.
        st_d.req = st_d.req | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.req <= '0;
            st_q.en  <= EN_RESET;
            st_q.lvl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (IS_NMI) begin
            if (bsel == BYTE_STAT) rdata = {4'h0, st_q.req};
        end else begin
            if (bsel == BYTE_STAT)     rdata = {st_q.req, st_q.req & st_q.en};
            else if (bsel == BYTE_CFG) rdata = {1'b0, st_q.lvl, st_q.en};
        end
    end

    assign nmi_fire = IS_NMI && (|line_evt) && (|(st_d.req & st_q.en));
    assign state    = st_q;

endmodule

// File: rtl/irq_group_regfile.sv
module irq_group_regfile
    import irq_grp_pkg::*;
#(
    parameter int NUM_GROUPS = GRP_COUNT,
    parameter int NUM_NMI    = GRP_NMI,
    localparam int NLINES    = NUM_GROUPS * GRP_LINES,
    localparam int ADDR_W    = $clog2(NUM_GROUPS * 4),
    localparam int GIDX_W    = ADDR_W - 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NLINES-1:0]             irq_in,
    input  logic [NLINES-1:0]             line_edge_mode,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [7:0]                    bus_wdata,
    output logic [7:0]                    bus_rdata,
    output logic                          nmi_pulse,
    output logic [NLINES-1:0]             req_vec,
    output logic [NLINES-1:0]             en_vec,
    output logic [NUM_GROUPS*GRP_LVL_W-1:0] lvl_vec
);

    logic [GIDX_W-1:0]   gidx;
    logic [1:0]          bsel;
    logic [7:0]          slot_rd [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] fire_v;

    assign gidx = bus_addr[ADDR_W-1:2];
    assign bsel = bus_addr[1:0];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GRP_LINES-1:0] evt;
        logic [GRP_LINES-1:0] setb;
        grp_state_t           st;
        logic                 hit;

        assign hit = bus_we && (gidx == GIDX_W'(g));

        irq_line_capture u_cap (
            .clk       (clk),
            .rst       (rst),
            .line_in   (irq_in[g*GRP_LINES +: GRP_LINES]),
            .edge_mode (line_edge_mode[g*GRP_LINES +: GRP_LINES]),
            .line_evt  (evt),
            .set_bits  (setb)
        );

        irq_group_slot #(.IS_NMI(g < NUM_NMI)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_hit   (hit),
            .byte_sel (bsel),
            .wdata    (bus_wdata),
            .set_bits (setb),
            .line_evt (evt),
            .rdata    (slot_rd[g]),
            .state    (st),
            .nmi_fire (fire_v[g])
        );

        assign req_vec[g*GRP_LINES +: GRP_LINES] = st.req;
        assign en_vec[g*GRP_LINES +: GRP_LINES]  = st.en;
        assign lvl_vec[g*GRP_LVL_W +: GRP_LVL_W] = st.lvl;
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (int'(gidx) < NUM_GROUPS) bus_rdata = slot_rd[gidx];
    end

    always_ff @(posedge clk) begin
        if (rst) nmi_pulse <= 1'b0;
        else     nmi_pulse <= |fire_v;
    end

endmodule

// File: rtl/irq_group_regfile_chk.sv
module irq_group_regfile_chk
    import irq_grp_pkg::*;
#(
    parameter int NUM_GROUPS = GRP_COUNT,
    parameter int NUM_NMI    = GRP_NMI,
    localparam int NLINES    = NUM_GROUPS * GRP_LINES,
    localparam int ADDR_W    = $clog2(NUM_GROUPS * 4),
    localparam int NMI_LINES = NUM_NMI * GRP_LINES
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NLINES-1:0]             irq_in,
    input logic [NLINES-1:0]             line_edge_mode,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          bus_we,
    input logic [7:0]                    bus_rdata,
    input logic                          nmi_pulse,
    input logic [NLINES-1:0]             req_vec,
    input logic [NLINES-1:0]             en_vec,
    input logic [NUM_GROUPS*GRP_LVL_W-1:0] lvl_vec
);

    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) >= NUM_GROUPS * 4) |-> (bus_rdata == 8'h00));

    a_r3_level_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(lvl_vec));

    a_r5_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> (($past(req_vec) & ~req_vec) == '0));

    a_r7_nmi_enable_fixed: assert property (@(posedge clk) disable iff (rst)
        en_vec[NMI_LINES-1:0] == {NMI_LINES{1'b1}});

    a_r10_nmi_enabled_req: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |-> (|(req_vec[NMI_LINES-1:0] & en_vec[NMI_LINES-1:0])));

    for (genvar i = 0; i < NLINES; i++) begin : g_lvl
        a_r9_level_sets: assert property (@(posedge clk) disable iff (rst)
            (!line_edge_mode[i] && irq_in[i]) |=> req_vec[i]);
    end

endmodule

bind irq_group_regfile irq_group_regfile_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_NMI    (NUM_NMI)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .irq_in         (irq_in),
    .line_edge_mode (line_edge_mode),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_rdata      (bus_rdata),
    .nmi_pulse      (nmi_pulse),
    .req_vec        (req_vec),
    .en_vec         (en_vec),
    .lvl_vec        (lvl_vec)
);

// File: tb/irq_group_regfile_test.sv
`timescale 1ns/1ps
module irq_group_regfile_test;
    localparam int NL = 124;

    logic           clk = 1'b0;
    logic           rst;
    logic [NL-1:0]  irq_in;
    logic [NL-1:0]  line_edge_mode;
    logic [6:0]     bus_addr;
    logic           bus_we;
    logic [7:0]     bus_wdata;
    logic [7:0]     bus_rdata;
    logic           nmi_pulse;
    logic [NL-1:0]  req_vec;
    logic [NL-1:0]  en_vec;
    logic [92:0]    lvl_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_group_regfile uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .line_edge_mode(line_edge_mode),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .nmi_pulse(nmi_pulse), .req_vec(req_vec),
        .en_vec(en_vec), .lvl_vec(lvl_vec)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [6:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, {120'd0, bus_rdata}, {120'd0, exp});
    endtask

    task automatic t_reset;
        check("R1 req_vec", req_vec, '0);
        check("R1 lvl_vec", lvl_vec, '0);
        check("R1 en_vec", en_vec, {116'd0, 8'hFF});
        check("R1 nmi_pulse", nmi_pulse, 0);
        read_check("R1 g5 cfg", 7'd21, 8'h00);
    endtask

    task automatic t_cfg;
        bus_write(7'd21, 8'h5A);
        read_check("R3 g5 cfg", 7'd21, 8'h5A);
        check("R12 lvl_vec g5", lvl_vec[15 +: 3], 3'd5);
        check("R12 en_vec g5", en_vec[20 +: 4], 4'hA);
        bus_write(7'd21, 8'hDA);
        read_check("R3 bit7 dropped", 7'd21, 8'h5A);
    endtask

    task automatic t_edge;
        @(negedge clk); irq_in[21] = 1'b1;
        @(negedge clk);
        check("R12 req_vec bit21", req_vec[21], 1);
        read_check("R4 g5 stat", 7'd20, 8'h22);
        check("R10 maskable no nmi", nmi_pulse, 0);
        bus_write(7'd20, 8'h02);
        read_check("R5 g5 cleared", 7'd20, 8'h00);
        @(negedge clk); irq_in[21] = 1'b0;
        @(negedge clk);
        read_check("R8 falling edge sets", 7'd20, 8'h22);
    endtask

    task automatic t_level;
        @(negedge clk); irq_in[26] = 1'b1;
        @(negedge clk);
        read_check("R9 level set", 7'd24, 8'h40);
        bus_write(7'd24, 8'h04);
        read_check("R9 clear while high", 7'd24, 8'h40);
        @(negedge clk); irq_in[26] = 1'b0;
        @(negedge clk);
        read_check("R9 low keeps", 7'd24, 8'h40);
        bus_write(7'd24, 8'h04);
        read_check("R9 clear after low", 7'd24, 8'h00);
    endtask

    task automatic t_pairs;
        bus_write(7'd28, 8'hFF);
        read_check("R5 set all", 7'd28, 8'hF0);
        bus_write(7'd28, 8'h0A);
        read_check("R5 clear 1,3", 7'd28, 8'h50);
        bus_write(7'd28, 8'hA0);
        read_check("R5 L=0 keeps", 7'd28, 8'h50);
        bus_write(7'd28, 8'h31);
        read_check("R5 mixed", 7'd28, 8'h50);
    endtask

    task automatic t_nmi_regs;
        bus_write(7'd3, 8'h05);
        check("R10 inject no pulse", nmi_pulse, 0);
        read_check("R7 inject", 7'd0, 8'h05);
        bus_write(7'd0, 8'h01);
        read_check("R6 w1c", 7'd0, 8'h04);
        bus_write(7'd0, 8'h04);
        read_check("R6 w1c all", 7'd0, 8'h00);
        bus_write(7'd5, 8'h00);
        check("R7 en fixed", en_vec[7:4], 4'hF);
        read_check("R7 cfg zero", 7'd5, 8'h00);
    endtask

    task automatic t_nmi_pulse;
        @(negedge clk); irq_in[4] = 1'b1;
        @(negedge clk);
        check("R10 pulse high", nmi_pulse, 1);
        read_check("R6 g1 stat", 7'd4, 8'h01);
        @(negedge clk);
        check("R10 pulse one cycle", nmi_pulse, 0);
    endtask

    task automatic t_unmapped;
        bus_write(7'd124, 8'hFF);
        read_check("R2 above range", 7'd124, 8'h00);
        read_check("R2 reserved byte", 7'd22, 8'h00);
        check("R2 no side effect", req_vec[123:32], '0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        irq_in[32] = 1'b1;
        bus_addr = 7'd32; bus_wdata = 8'h01; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        read_check("R11 input wins", 7'd32, 8'h10);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        line_edge_mode = '1;
        line_edge_mode[26] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_cfg;
        t_edge;
        t_level;
        t_pairs;
        t_unmapped;
        t_nmi_regs;
        t_nmi_pulse;
        t_collide;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule